// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a 32-bit register port. A slow tick-enable input, nominally 32 kHz, drives a down-counter. Software keeps the system alive by writing a restart code before the counter runs out. If the counter expires while it is enabled, the block pulses a system reset output. It can also drive an external reset pin at a programmable level and set a sticky interrupt flag. Software can force the same reset pulse at any time through a dedicated register.

Every write that changes state must carry a key that belongs to its register: a byte in the mode register, a five-bit tag in the length register, and a full-word code in the restart and software-reset registers. A write with the wrong key leaves all state as it was. The timeout is programmed in coarse units of `TICKS_PER_UNIT` ticks. With the default of 512 ticks, 64 units make one second at 32 kHz.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `sys_rst` and `irq` are 0 and `ext_rst` is 1. The mode register (offset 0x00) reads 0. The length register (offset 0x04) reads `LEN_RESET << 5`. Offsets 0x08 and 0x14 read 0.
- R2: A write to offset 0x00 takes effect only when bits [31:24] equal 0x22. The register holds the following fields, and all other read bits are 0, including the key byte:

  | Bit | Function |
  |-----|----------|
  | 0 | enable |
  | 1 | external pin polarity (1 = active high) |
  | 2 | external pin enable |
  | 3 | interrupt enable |
  | 4 | auto-start (stored only) |
  | 6 | dual mode (stored only) |

- R3: A write to offset 0x04 is accepted only when bits [4:0] equal 0x08. The timeout field is bits [5+LEN_W-1:5], and reads return that field at the same position with every other bit 0.
- R4: With enable set, `sys_rst` rises on the clock edge of the (length × `TICKS_PER_UNIT`)-th tick after the last load. It stays high for exactly `PULSE_TICKS` ticks. At expiry the counter reloads from the length register.
- R5: Writing exactly 0x00001971 to offset 0x08 reloads the counter and clears `irq`. Any other value reloads nothing and leaves `irq` unchanged.
- R6: A length write does not reload the counter. The new value is used from the next load on, which is a restart, a 0-to-1 change of enable, or an expiry.
- R7: Writing exactly 0x00001209 to offset 0x14 starts a `PULSE_TICKS`-tick reset pulse on the next edge, whether or not enable is set. Other values, or the same value at another offset, have no effect.
- R8: `ext_rst` equals the polarity bit while a pulse is active and the external enable is set. At all other times it equals the inverse of the polarity bit.
- R9: An expiry sets `irq` when interrupt enable is set, and `irq` then holds until R5 clears it. A software reset never sets `irq`, and neither does an expiry with interrupt enable clear.
- R10: Clearing enable stops the counter without any reset pulse. Setting enable again loads a full timeout.
- R11: The counter and the pulse length advance only on cycles where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase enable, one cycle per slow tick |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data including key |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| sys_rst | output | 1 | System reset pulse, active high |
| ext_rst | output | 1 | External reset pin at the programmed polarity |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
A counter that is off by one shifts the `sys_rst` edge by one tick, and every timeout sweep measures that edge exactly. A wrong load source shows up only one expiry later: a length write that reloads too early, or an expiry reload that uses stale data. For that reason the bench waits through a second full period. A key decode that is too loose shows up at once as a changed readback on the next cycle. Faulty pulse-counter or polarity logic shows up during the pulse itself, as a wrong width or level on `sys_rst` and `ext_rst`.

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog #(
  parameter int TICKS_PER_UNIT = 512,
  parameter int LEN_W          = 11,
  parameter int PULSE_TICKS    = 4,
  parameter int ADDR_W         = 8,
  parameter int LEN_RESET      = 1984
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst,
  output logic              ext_rst,
  output logic              irq
);
  localparam int CNT_W = LEN_W + $clog2(TICKS_PER_UNIT);
  localparam int PW    = $clog2(PULSE_TICKS + 1);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(8'h14);

  logic             mode_en, mode_pol, mode_ext, mode_irq, mode_auto, mode_dual;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic [PW-1:0]    pcnt;
  logic [CNT_W-1:0] reload;
  logic wr, wr_mode, wr_len, wr_kick, wr_swrst, load, expire;

  assign wr       = bus_valid & bus_write;
  assign wr_mode  = wr && bus_addr == A_MODE  && bus_wdata[31:24] == 8'h22;
  assign wr_len   = wr && bus_addr == A_LEN   && bus_wdata[4:0] == 5'h08;
  assign wr_kick  = wr && bus_addr == A_KICK  && bus_wdata == 32'h0000_1971;
  assign wr_swrst = wr && bus_addr == A_SWRST && bus_wdata == 32'h0000_1209;

  assign reload = CNT_W'(len) * CNT_W'(TICKS_PER_UNIT);
  assign load   = wr_kick | (wr_mode & bus_wdata[0] & ~mode_en);
  assign expire = mode_en & tick & ~load & (cnt <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {mode_en, mode_pol, mode_ext, mode_irq, mode_auto, mode_dual} <= '0;
    end else if (wr_mode) begin
      mode_en   <= bus_wdata[0];
      mode_pol  <= bus_wdata[1];
      mode_ext  <= bus_wdata[2];
      mode_irq  <= bus_wdata[3];
      mode_auto <= bus_wdata[4];
      mode_dual <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len <= LEN_W'(LEN_RESET);
    else if (wr_len) len <= bus_wdata[5 +: LEN_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (load || expire)   cnt <= reload;
    else if (mode_en && tick)  cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pcnt <= '0;
    else if (expire || wr_swrst)     pcnt <= PW'(PULSE_TICKS);
    else if (tick && pcnt != '0)     pcnt <= pcnt - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (expire && mode_irq) irq <= 1'b1;
    else if (wr_kick)            irq <= 1'b0;
  end

  assign sys_rst = pcnt != '0;
  assign ext_rst = (sys_rst && mode_ext) ? mode_pol : ~mode_pol;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {25'd0, mode_dual, 1'b0, mode_auto, mode_irq, mode_ext, mode_pol, mode_en};
      A_LEN:   bus_rdata = 32'(len) << 5;
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
`timescale 1ns/1ps
module keyed_watchdog_chk #(
  parameter int LEN_W  = 11,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              sys_rst,
  input logic              ext_rst,
  input logic              irq,
  input logic              en,
  input logic              pol,
  input logic              ext_en,
  input logic              irq_en,
  input logic              auto_st,
  input logic              dual,
  input logic [LEN_W-1:0]  len
);
  logic wr, swrst_wr, kick_wr;
  assign wr       = bus_valid && bus_write;
  assign swrst_wr = wr && bus_addr == ADDR_W'(8'h14) && bus_wdata == 32'h0000_1209;
  assign kick_wr  = wr && bus_addr == ADDR_W'(8'h08) && bus_wdata == 32'h0000_1971;

  assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h00) && bus_wdata[31:24] != 8'h22)
      |=> $stable({en, pol, ext_en, irq_en, auto_st, dual}));

  assert_len_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(8'h04) && bus_wdata[4:0] != 5'h08) |=> $stable(len));

  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ($past(en && tick) || $past(swrst_wr)));

  assert_ext_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en |-> ext_rst == !pol);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en && en && tick));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(kick_wr));

  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !swrst_wr) |=> !$rose(sys_rst));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sys_rst(sys_rst), .ext_rst(ext_rst),
  .irq(irq), .en(mode_en), .pol(mode_pol), .ext_en(mode_ext), .irq_en(mode_irq),
  .auto_st(mode_auto), .dual(mode_dual), .len(len)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int TPU = 4, LW = 11, PT = 4, LRST = 5;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sys_rst, ext_rst, irq;

  int vectors = 0, fails = 0, tick_div = 1, phase = 0;
  int unsigned tick_seen = 0;
  bit done = 0;

  keyed_watchdog #(.TICKS_PER_UNIT(TPU), .LEN_W(LW), .PULSE_TICKS(PT), .ADDR_W(8), .LEN_RESET(LRST)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_rst(sys_rst), .ext_rst(ext_rst), .irq(irq));

  always #10 clk = ~clk;

  initial forever begin
    @(posedge clk); #2;
    phase++;
    tick = (tick_div == 1) ? 1'b1 : (phase % tick_div == 0);
  end

  initial forever begin
    @(posedge clk);
    if (rst_n && tick) tick_seen++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] mw(input bit en, input bit pol, input bit ext, input bit ie);
    return {8'h22, 20'h0, ie, ext, pol, en};
  endfunction

  function automatic logic [31:0] lw(input int l);
    return (32'(l) << 5) | 32'h8;
  endfunction

  task automatic wait_rst(input int unsigned t0, output int el);
    int c = 0;
    while (!sys_rst && c < 2000) begin @(negedge clk); c++; end
    el = sys_rst ? int'(tick_seen - t0) : -1;
  endtask

  task automatic pulse_len(output int el);
    int unsigned t0 = tick_seen;
    int c = 0;
    while (sys_rst && c < 2000) begin @(negedge clk); c++; end
    el = int'(tick_seen - t0);
  endtask

  task automatic quiet;
    wr(8'h00, mw(0, 0, 0, 0));
    while (sys_rst) @(negedge clk);
  endtask

  task automatic run_timeout(input int l, input string req);
    int el, pl;
    int unsigned t0;
    wr(8'h04, lw(l));
    wr(8'h00, mw(1, 0, 0, 0));
    t0 = tick_seen;
    wait_rst(t0, el);
    chk(req, el, l * TPU);
    pulse_len(pl);
    chk(req, pl, PT);
    quiet();
  endtask

  initial begin
    logic [31:0] r, exp_mode, exp_len, d;
    int el, pl;
    int unsigned t0, te;
    bit seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 sys_rst", sys_rst, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ext_rst", ext_rst, 1);
    rd(8'h00, r); chk("R1 mode", r, 0);
    rd(8'h04, r); chk("R1 len", r, LRST << 5);
    rd(8'h08, r); chk("R1 kick", r, 0);
    rd(8'h14, r); chk("R1 swrst", r, 0);

    exp_mode = 0;
    for (int k = 0; k < 256; k++) begin
      d = {8'(k), 16'hFFFF, 8'(k) ^ 8'h5C};
      wr(8'h00, d);
      if (k == 8'h22) exp_mode = {24'd0, d[7:0] & 8'h5F};
      rd(8'h00, r); chk("R2 mode key", r, exp_mode);
    end
    wr(8'h00, mw(0, 0, 0, 0));

    exp_len = LRST << 5;
    for (int j = 0; j < 32; j++) begin
      d = {16'hABCD, 11'(7 + j), 5'(j)};
      wr(8'h04, d);
      if (j == 8) exp_len = 32'(7 + j) << 5;
      rd(8'h04, r); chk("R3 len key", r, exp_len);
    end

    for (int l = 2; l <= 12; l++) run_timeout(l, "R4 timeout");
    tick_div = 3;
    run_timeout(3, "R11 sparse tick");
    run_timeout(7, "R11 sparse tick");
    tick_div = 1;

    wr(8'h04, lw(6));
    wr(8'h00, mw(1, 0, 0, 0));
    repeat (10) @(negedge clk);
    wr(8'h08, 32'h0000_1971);
    t0 = tick_seen;
    wait_rst(t0, el); chk("R5 restart reload", el, 24);
    quiet();
    wr(8'h00, mw(1, 0, 0, 0));
    t0 = tick_seen;
    repeat (10) @(negedge clk);
    wr(8'h08, 32'h0000_1970);
    wr(8'h08, 32'h0001_1971);
    wait_rst(t0, el); chk("R5 bad restart ignored", el, 24);
    quiet();

    wr(8'h04, lw(4));
    wr(8'h00, mw(1, 0, 0, 0));
    t0 = tick_seen;
    repeat (3) @(negedge clk);
    wr(8'h04, lw(10));
    wait_rst(t0, el); chk("R6 no reload on length write", el, 16);
    te = tick_seen;
    pulse_len(pl);
    wait_rst(te, el); chk("R6 new length at next load", el, 40);
    quiet();

    wr(8'h04, lw(3));
    wr(8'h00, mw(1, 0, 0, 0));
    repeat (5) @(negedge clk);
    wr(8'h00, mw(0, 0, 0, 0));
    seen = 0;
    for (int c = 0; c < 60; c++) begin @(negedge clk); if (sys_rst) seen = 1; end
    chk("R10 stop without reset", seen, 0);
    wr(8'h00, mw(1, 0, 0, 0));
    t0 = tick_seen;
    wait_rst(t0, el); chk("R10 full timeout after re-enable", el, 12);
    quiet();

    wr(8'h14, 32'h0000_1208);
    wr(8'h10, 32'h0000_1209);
    seen = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (sys_rst) seen = 1; end
    chk("R7 bad swrst ignored", seen, 0);
    wr(8'h14, 32'h0000_1209);
    chk("R7 swrst immediate", sys_rst, 1);
    pulse_len(pl); chk("R7 swrst pulse", pl, PT);

    wr(8'h00, mw(0, 1, 1, 0));
    chk("R8 idle high-pol", ext_rst, 0);
    wr(8'h14, 32'h0000_1209);
    chk("R8 active high-pol", ext_rst, 1);
    pulse_len(pl);
    chk("R8 after pulse high-pol", ext_rst, 0);
    wr(8'h00, mw(0, 0, 1, 0));
    chk("R8 idle low-pol", ext_rst, 1);
    wr(8'h14, 32'h0000_1209);
    chk("R8 active low-pol", ext_rst, 0);
    pulse_len(pl);
    chk("R8 after pulse low-pol", ext_rst, 1);
    wr(8'h00, mw(0, 1, 0, 0));
    wr(8'h14, 32'h0000_1209);
    chk("R8 pin disabled", ext_rst, 0);
    chk("R8 pin disabled sys_rst", sys_rst, 1);
    pulse_len(pl);

    wr(8'h04, lw(2));
    wr(8'h00, mw(1, 0, 0, 1));
    t0 = tick_seen;
    chk("R9 irq clear before expiry", irq, 0);
    wait_rst(t0, el);
    chk("R9 irq set on expiry", irq, 1);
    pulse_len(pl);
    chk("R9 irq sticky", irq, 1);
    wr(8'h08, 32'h0000_1970);
    chk("R9 irq kept on bad restart", irq, 1);
    wr(8'h08, 32'h0000_1971);
    chk("R5 irq cleared by restart", irq, 0);
    quiet();
    wr(8'h00, mw(0, 0, 0, 1));
    wr(8'h14, 32'h0000_1209);
    pulse_len(pl);
    chk("R9 swrst sets no irq", irq, 0);
    wr(8'h00, mw(1, 0, 0, 0));
    t0 = tick_seen;
    wait_rst(t0, el);
    pulse_len(pl);
    chk("R9 irq disabled", irq, 0);
    quiet();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule